// File: doc/BRIEF.md
# Power-up Identification ROM Reader

This block fetches a run of identification bytes from an external two-wire serial ROM as soon as reset is released. No command starts it. It drives the clock line and pulls the shared data line low through an open-drain enable. It never drives the data line high. The block issues a start condition, then shifts out the byte address to read and checks the ROM's acknowledge. It then clocks in data bytes one after another. It acknowledges every byte except the last, so the ROM keeps streaming sequential locations. After the last byte it issues a stop condition.

Each received byte appears on a byte bus with a single-cycle valid strobe, in arrival order. When the sequence ends, a sticky done flag rises. A sticky error flag also rises if the ROM did not acknowledge the address. The bit period comes from a clock divider. One bit lasts four quarter periods of `DIV` system clocks each, and `DIV` must be at least 2. `NUM_BYTES` (at least 1) sets the burst length, and `START_ADDR` sets the first location read.

Top module: `idrom_reader`

## Requirements
- R1: While reset is held, the clock line is high, the data line is released (`sdaOe` = 0), and `done`, `error` and `byteValid` are 0. After reset is released the read sequence runs with no further input.
- R2: Each run begins with exactly one start condition: the data line falls while the clock line is high, before the first clock low phase.
- R3: In the first eight clock pulses after the start, the reader sends `START_ADDR` most significant bit first.
- R4: In the ninth clock of the address transfer the reader releases the data line. A low level sampled there lets the run continue to data bytes with `error` left at 0.
- R5: Exactly `NUM_BYTES` bytes are received, most significant bit first. Each one is presented on `byteData` with a one-cycle `byteValid` pulse, in the order the ROM sends them.
- R6: In the ninth clock of every data byte except the last, the reader pulls the data line low (acknowledge). For the last byte it leaves the line released.
- R7: Each run ends with exactly one stop condition: the data line rises while the clock line is high. `done` then stays at 1 and the clock line stays high until the next reset.
- R8: If the address is not acknowledged, `error` becomes 1, a stop condition follows, `done` becomes 1, and no `byteValid` pulse is produced.
- R9: Apart from the start and stop conditions, the data line never changes while the clock line is high.
- R10: During bit transfers the clock line is high for 2*DIV system clocks and low for 2*DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; its release starts a run |
| sdaIn | input | 1 | Level sensed on the shared data line |
| sclOut | output | 1 | Serial clock line |
| sdaOe | output | 1 | Pull-down enable for the data line (1 = drive low, 0 = released) |
| byteData | output | 8 | Last received ID byte |
| byteValid | output | 1 | One-cycle strobe marking a new byte on `byteData` |
| done | output | 1 | Sticky flag: the run has finished with its stop condition |
| error | output | 1 | Sticky flag: the address was not acknowledged |

## Verification
The emission of a received byte and the choice of what to drive in that byte's ninth clock happen on the same clock edge. On the last byte, the valid pulse coincides with the decision to withhold the acknowledge and head for the stop. A behavioural ROM on the bench records every acknowledge level the reader presents and every start and stop edge it sees. The bench judges this edge by checking that all bytes arrive in order and that the recorded acknowledges read low for all bytes but the final one, which reads released. A second run with the ROM refusing the address makes the acknowledge check and the stop decision fall together, and the bench confirms the error flag and an empty byte stream.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  typedef enum logic [1:0] {
    LM_IDLE  = 2'd0,
    LM_START = 2'd1,
    LM_BITS  = 2'd2,
    LM_STOP  = 2'd3
  } lineMode_e;

  typedef struct packed {
    lineMode_e mode;      // which waveform the line generator produces
    logic      loadAddr;  // preload the transmit shifter with the address
    logic      rxDir;     // bits 0..7 come from the ROM (line released)
    logic      ackDrive;  // pull the line low in the ninth clock
  } ctlStrobe_t;

endpackage

// File: rtl/idrom_datapath.sv
module idrom_datapath
  import idrom_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic [7:0] addrByte,
  input  logic       sdaIn,
  output logic       sclOut,
  output logic       sdaOe,
  output logic       segEnd,
  output logic       bitEnd,
  output logic [3:0] bitIdx,
  output logic [7:0] rxByte,
  output logic       ackLow
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       phase;
  logic             qTick;
  logic             sampleNow;
  logic [7:0]       txReg;
  logic             sclNext;
  logic             sdaLowNext;
  logic             sdaLowDly;

  assign qTick     = (divCnt == DIV_LAST);
  assign segEnd    = qTick && (phase == 2'd3);
  assign bitEnd    = segEnd && (ctl.mode == LM_BITS);
  assign sampleNow = qTick && (phase == 2'd2) && (ctl.mode == LM_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 2'd0;
    end else begin
      divCnt <= qTick ? '0 : divCnt + 1'b1;
      if (qTick) phase <= phase + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= 4'd0;
    end else if (ctl.mode != LM_BITS) begin
      bitIdx <= 4'd0;
    end else if (bitEnd) begin
      bitIdx <= (bitIdx == ACK_SLOT) ? 4'd0 : bitIdx + 4'd1;
    end
  end

  // transmit shifter advances only at bit boundaries (clock low next)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= 8'hFF;
    end else if (ctl.loadAddr) begin
      txReg <= addrByte;
    end else if (bitEnd && (bitIdx != ACK_SLOT)) begin
      txReg <= {txReg[6:0], 1'b1};
    end
  end

  // receive sampling in the middle of the clock-high half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= 8'h00;
      ackLow <= 1'b0;
    end else if (sampleNow) begin
      if (bitIdx == ACK_SLOT) ackLow <= ~sdaIn;
      else                    rxByte <= {rxByte[6:0], sdaIn};
    end
  end

  always_comb begin
    sclNext    = 1'b1;
    sdaLowNext = 1'b0;
    unique case (ctl.mode)
      LM_IDLE: begin
        sclNext    = 1'b1;
        sdaLowNext = 1'b0;
      end
      LM_START: begin
        sclNext    = 1'b1;
        sdaLowNext = phase[1];
      end
      LM_BITS: begin
        sclNext = phase[1];
        if (bitIdx == ACK_SLOT) sdaLowNext = ctl.ackDrive;
        else                    sdaLowNext = ctl.rxDir ? 1'b0 : ~txReg[7];
      end
      LM_STOP: begin
        sclNext    = (phase != 2'd0);
        sdaLowNext = ~phase[1];
      end
      default: begin
        sclNext    = 1'b1;
        sdaLowNext = 1'b0;
      end
    endcase
  end

  // data line trails the clock line by one cycle so it moves with clock low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOut    <= 1'b1;
      sdaLowDly <= 1'b0;
      sdaOe     <= 1'b0;
    end else begin
      sclOut    <= sclNext;
      sdaLowDly <= sdaLowNext;
      sdaOe     <= sdaLowDly;
    end
  end

  assert_sample_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleNow |-> sclOut)
    else $error("sampling while clock line low");

  assert_bit_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= ACK_SLOT)
    else $error("bit index out of range");

  assert_seg_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    segEnd |=> !segEnd)
    else $error("segment ends too close together");

endmodule

// File: rtl/idrom_ctrl.sv
module idrom_ctrl
  import idrom_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       segEnd,
  input  logic       bitEnd,
  input  logic [3:0] bitIdx,
  input  logic       ackLow,
  input  logic [7:0] rxByte,
  output ctlStrobe_t ctl,
  output logic [7:0] byteData,
  output logic       byteValid,
  output logic       done,
  output logic       error
);

  localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_READ, S_STOP, S_DONE
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] byteCnt;
  logic             lastByte;
  logic             byteEnd;
  logic             dataDone;

  assign lastByte = (byteCnt == LAST_IDX);
  assign byteEnd  = bitEnd && (bitIdx == 4'd8);
  assign dataDone = bitEnd && (bitIdx == 4'd7);

  always_comb begin
    ctl          = '0;
    ctl.mode     = LM_IDLE;
    ctl.loadAddr = (state == S_IDLE);
    unique case (state)
      S_START: ctl.mode = LM_START;
      S_ADDR:  ctl.mode = LM_BITS;
      S_READ: begin
        ctl.mode     = LM_BITS;
        ctl.rxDir    = 1'b1;
        ctl.ackDrive = !lastByte;
      end
      S_STOP:  ctl.mode = LM_STOP;
      default: ctl.mode = LM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      byteCnt   <= '0;
      byteData  <= 8'h00;
      byteValid <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      unique case (state)
        S_IDLE:  if (segEnd) state <= S_START;
        S_START: if (segEnd) state <= S_ADDR;
        S_ADDR: begin
          if (byteEnd) begin
            if (ackLow) begin
              state   <= S_READ;
              byteCnt <= '0;
            end else begin
              error <= 1'b1;
              state <= S_STOP;
            end
          end
        end
        S_READ: begin
          if (dataDone) begin
            byteValid <= 1'b1;
            byteData  <= rxByte;
          end
          if (byteEnd) begin
            if (lastByte) state <= S_STOP;
            else          byteCnt <= byteCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (segEnd) begin
            state <= S_DONE;
            done  <= 1'b1;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid)
    else $error("byte strobe longer than one cycle");

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done)
    else $error("done dropped");

  assert_nack_stops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && byteEnd && !ackLow) |=> (state == S_STOP && error))
    else $error("missing acknowledge not handled");

  assert_err_no_bytes_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !byteValid)
    else $error("byte emitted after address refusal");

endmodule

// File: rtl/idrom_reader.sv
module idrom_reader
  import idrom_pkg::*;
#(
  parameter int         DIV        = 4,
  parameter int         NUM_BYTES  = 4,
  parameter logic [7:0] START_ADDR = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  output logic       sclOut,
  output logic       sdaOe,
  output logic [7:0] byteData,
  output logic       byteValid,
  output logic       done,
  output logic       error
);

  ctlStrobe_t ctl;
  logic       segEnd;
  logic       bitEnd;
  logic [3:0] bitIdx;
  logic [7:0] rxByte;
  logic       ackLow;

  idrom_ctrl #(.NUM_BYTES(NUM_BYTES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .segEnd   (segEnd),
    .bitEnd   (bitEnd),
    .bitIdx   (bitIdx),
    .ackLow   (ackLow),
    .rxByte   (rxByte),
    .ctl      (ctl),
    .byteData (byteData),
    .byteValid(byteValid),
    .done     (done),
    .error    (error)
  );

  idrom_datapath #(.DIV(DIV)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrByte(START_ADDR),
    .sdaIn   (sdaIn),
    .sclOut  (sclOut),
    .sdaOe   (sdaOe),
    .segEnd  (segEnd),
    .bitEnd  (bitEnd),
    .bitIdx  (bitIdx),
    .rxByte  (rxByte),
    .ackLow  (ackLow)
  );

endmodule

// File: tb/sim_idrom_reader.sv
`timescale 1ns/1ps
module sim_idrom_reader;

  localparam int         DIV   = 2;
  localparam int         NB    = 5;
  localparam logic [7:0] SADDR = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclOut, sdaOe, byteValid, done, error;
  logic [7:0] byteData;
  logic romLow = 1'b0;
  logic sdaBus;

  assign sdaBus = !(sdaOe || romLow);

  always #4 clk = ~clk;

  idrom_reader #(.DIV(DIV), .NUM_BYTES(NB), .START_ADDR(SADDR)) u0 (
    .clk(clk), .rstN(rstN), .sdaIn(sdaBus), .sclOut(sclOut), .sdaOe(sdaOe),
    .byteData(byteData), .byteValid(byteValid), .done(done), .error(error)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // ROM model state and logs
  bit         romAckEn = 1'b1;
  logic [7:0] gotAddr;
  bit         masterAck [0:31];
  int         ackCnt = 0;
  int         startCnt = 0;
  int         stopCnt = 0;
  logic [7:0] rxLog [0:31];
  int         rxCnt = 0;

  function automatic logic [7:0] romData(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural serial ROM
  initial begin
    logic [7:0] a;
    logic [7:0] ptr;
    logic [7:0] d;
    bit go;
    forever begin
      do @(negedge sdaBus); while (sclOut !== 1'b1);
      a = 8'h00;
      for (int i = 0; i < 8; i++) begin
        @(posedge sclOut);
        a = {a[6:0], sdaBus};
      end
      gotAddr = a;
      @(negedge sclOut); #1 romLow = romAckEn;
      @(negedge sclOut); #1 romLow = 1'b0;
      go  = romAckEn;
      ptr = a;
      while (go) begin
        d = romData(ptr);
        for (int b = 7; b >= 0; b--) begin
          romLow = ~d[b];
          @(negedge sclOut); #1;
        end
        romLow = 1'b0;
        @(posedge sclOut);
        go = !sdaBus;
        if (ackCnt < 32) masterAck[ackCnt] = go;
        ackCnt++;
        @(negedge sclOut); #1;
        ptr = ptr + 8'd1;
      end
    end
  end

  // line condition monitor: any data edge while clock high counts here
  always @(negedge sdaBus) if (sclOut === 1'b1) startCnt++;
  always @(posedge sdaBus) if (sclOut === 1'b1) stopCnt++;

  always @(negedge clk) begin
    if (rstN && byteValid === 1'b1) begin
      if (rxCnt < 32) rxLog[rxCnt] = byteData;
      rxCnt++;
    end
  end

  task automatic clearLogs();
    ackCnt = 0; startCnt = 0; stopCnt = 0; rxCnt = 0;
    gotAddr = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    clearLogs();
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, req, "done reached", done, 1);
  endtask

  task automatic test_reset();
    doReset();
    check(sclOut === 1'b1, "R1", "clock line in reset", sclOut, 1);
    check(sdaOe === 1'b0, "R1", "data line in reset", sdaOe, 0);
    check(done === 1'b0 && error === 1'b0, "R1", "flags in reset", {done, error}, 0);
    check(byteValid === 1'b0, "R1", "strobe in reset", byteValid, 0);
  endtask

  task automatic test_normal_read();
    int hi = 0;
    int lo = 0;
    romAckEn = 1'b1;
    doReset();
    rstN = 1'b1;
    @(posedge sclOut);
    check(startCnt == 1, "R2", "start before first pulse", startCnt, 1);
    @(negedge clk);
    while (sclOut === 1'b1) begin hi++; @(negedge clk); end
    while (sclOut === 1'b0) begin lo++; @(negedge clk); end
    check(hi == 2 * DIV, "R10", "clock high length", hi, 2 * DIV);
    check(lo == 2 * DIV, "R10", "clock low length", lo, 2 * DIV);
    waitDone("R7");
    check(gotAddr == SADDR, "R3", "address received", gotAddr, SADDR);
    check(error === 1'b0, "R4", "no error on ack", error, 0);
    check(rxCnt == NB, "R5", "byte count", rxCnt, NB);
    for (int i = 0; i < NB; i++)
      check(rxLog[i] == romData(SADDR + 8'(i)), "R5", "byte value",
            rxLog[i], romData(SADDR + 8'(i)));
    check(ackCnt == NB, "R6", "acknowledge slots", ackCnt, NB);
    for (int i = 0; i < NB; i++)
      check(masterAck[i] == (i != NB - 1), "R6", "acknowledge level",
            masterAck[i], (i != NB - 1));
    check(stopCnt == 1, "R7", "one stop", stopCnt, 1);
    check(startCnt + stopCnt == 2, "R9", "edges while clock high",
          startCnt + stopCnt, 2);
    repeat (100) @(negedge clk);
    check(done === 1'b1 && sclOut === 1'b1, "R7", "idle after stop",
          {done, sclOut}, 3);
    check(rxCnt == NB, "R7", "no bytes after stop", rxCnt, NB);
  endtask

  task automatic test_address_refused();
    romAckEn = 1'b0;
    doReset();
    rstN = 1'b1;
    waitDone("R8");
    check(error === 1'b1, "R8", "error flag", error, 1);
    check(rxCnt == 0, "R8", "no bytes emitted", rxCnt, 0);
    check(stopCnt == 1 && startCnt == 1, "R8", "start and stop",
          {startCnt[7:0], stopCnt[7:0]}, 16'h0101);
    check(ackCnt == 0, "R8", "no data slots", ackCnt, 0);
  endtask

  task automatic test_rerun();
    romAckEn = 1'b1;
    doReset();
    check(done === 1'b0 && error === 1'b0, "R1", "flags cleared", {done, error}, 0);
    rstN = 1'b1;
    waitDone("R1");
    check(error === 1'b0 && rxCnt == NB, "R1", "second run bytes", rxCnt, NB);
    check(rxLog[NB - 1] == romData(SADDR + 8'(NB - 1)), "R5", "last byte",
          rxLog[NB - 1], romData(SADDR + 8'(NB - 1)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_normal_read();
    test_address_refused();
    test_rerun();
    finish_run();
  end

endmodule